// File: doc/BRIEF.md
# Four-Phase Handshake Bus Bridge

This block pairs a bus master and a bus slave that live in two unrelated clock domains and talk over an unclocked request/acknowledge handshake. Arbitration is taken as already won. On the master side a local agent hands in read or write commands over a valid/ready port and gets one response per command back over a second valid/ready port. The master puts address, direction and write data on the shared lines, waits a fixed decode interval, and only then raises request.

The slave sees request through a synchronizer in its own clock. It answers with acknowledge: for a write once the word is stored in its register file, and for a read once the word is on the return data lines. The master sees acknowledge through its own synchronizer and drops request. For a read it latches the data at that moment. The slave drops acknowledge and releases the return lines once it sees request low. The master may present a new address only after it has seen acknowledge low. Back-pressure works on both ports: the command port takes no new command until the previous response has been accepted, and a response stays presented with unchanged data until `rsp_ready` is high on a master clock edge.

Top module: `hs_bus_top`

## Requirements
- R1: After reset, `cmd_ready` is high, and `rsp_valid`, `bus_req` and `bus_ack` are low.
- R2: A command is taken on a master clock edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` then stays low until the response for that command has been accepted.
- R3: `bus_req` rises exactly DECODE_CYC+1 master clock cycles after the command is taken. Address, direction and write data stay unchanged from acceptance until acknowledge has returned low.
- R4: Acknowledge rises only while request is high, and request falls only while acknowledge is high.
- R5: Acknowledge falls only while request is low, and request rises only while acknowledge is low. The pair {req,ack} therefore only steps 00, 10, 11, 01, 00.
- R6: A write (`cmd_write`=1) stores `cmd_wdata` at `cmd_addr`. A later read (`cmd_write`=0) of that address returns the most recently written word.
- R7: After the slave is reset, a location that has not been written reads as zero.
- R8: Each command produces exactly one response. `rsp_valid` stays high with `rsp_rdata` unchanged until `rsp_ready` is high on a master edge. A write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | Master clock |
| m_rst_n | input | 1 | Master active-low reset |
| s_clk | input | 1 | Slave clock |
| s_rst_n | input | 1 | Slave active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Master can take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Target word address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response presented |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| bus_req | output | 1 | Handshake request line, master domain |
| bus_ack | output | 1 | Handshake acknowledge line, slave domain |

## Verification
The hardest case to reach is a handshake edge that lands near a clock edge of the receiving domain while the other side is about to move on. That is where an ordering error or a torn read would show. The bench runs the two clocks at unrelated periods and sends several hundred random reads and writes back to back. The phase between the domains therefore drifts across all alignments. A free-running sampler with a fine time step follows every {req,ack} step. Directed cases add a read of an unwritten word, both end addresses, a rewrite of one address, a stalled response and a measured decode delay.

// File: rtl/hs_bus_pkg.sv
package hs_bus_pkg;
  typedef enum logic [2:0] {
    M_IDLE, M_SETUP, M_WAIT_ACK, M_WAIT_REL, M_RESP
  } m_state_e;

  typedef enum logic {
    S_IDLE, S_ACKED
  } s_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
  import hs_bus_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int DECODE_CYC  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              req,
  input  logic              ack_async,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int CNT_W = $clog2(DECODE_CYC + 1) + 1;

  m_state_e          state;
  logic [CNT_W-1:0]  cnt;
  logic              ack_s;
  logic [DATA_W-1:0] rdata_q;

  hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_async), .q(ack_s)
  );

  assign cmd_ready = (state == M_IDLE);
  assign rsp_valid = (state == M_RESP);
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= M_IDLE;
      cnt       <= '0;
      req       <= 1'b0;
      bus_addr  <= '0;
      bus_write <= 1'b0;
      bus_wdata <= '0;
      rdata_q   <= '0;
    end else begin
      unique case (state)
        M_IDLE: if (cmd_valid) begin
          bus_addr  <= cmd_addr;
          bus_write <= cmd_write;
          bus_wdata <= cmd_write ? cmd_wdata : '0;
          cnt       <= CNT_W'(DECODE_CYC);
          state     <= M_SETUP;
        end
        M_SETUP: begin
          if (cnt == '0) begin
            req   <= 1'b1;
            state <= M_WAIT_ACK;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        M_WAIT_ACK: if (ack_s) begin
          req     <= 1'b0;
          rdata_q <= bus_write ? '0 : bus_rdata;
          state   <= M_WAIT_REL;
        end
        M_WAIT_REL: if (!ack_s) state <= M_RESP;
        M_RESP:     if (rsp_ready) state <= M_IDLE;
        default:    state <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_bus_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_async,
  output logic              ack,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  s_state_e          state;
  logic              req_s;
  logic              drive;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] mem [DEPTH];

  hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_async), .q(req_s)
  );

  assign bus_rdata = drive ? rdata_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ack     <= 1'b0;
      drive   <= 1'b0;
      rdata_q <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_s) begin
          if (!bus_write) begin
            rdata_q <= mem[bus_addr];
            drive   <= 1'b1;
          end
          ack   <= 1'b1;
          state <= S_ACKED;
        end
        S_ACKED: if (!req_s) begin
          ack   <= 1'b0;
          drive <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (state == S_IDLE && req_s && bus_write && bus_addr == ADDR_W'(i))
        mem[i] <= bus_wdata;
    end
  end
endmodule

// File: rtl/hs_bus_top.sv
module hs_bus_top #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int DECODE_CYC  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              m_clk,
  input  logic              m_rst_n,
  input  logic              s_clk,
  input  logic              s_rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  output logic              bus_ack
);
  logic [ADDR_W-1:0] line_addr;
  logic              line_write;
  logic [DATA_W-1:0] line_wdata;
  logic [DATA_W-1:0] line_rdata;

  hs_master #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DECODE_CYC(DECODE_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_master (
    .clk(m_clk), .rst_n(m_rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .req(bus_req), .ack_async(bus_ack),
    .bus_addr(line_addr), .bus_write(line_write),
    .bus_wdata(line_wdata), .bus_rdata(line_rdata)
  );

  hs_slave #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_slave (
    .clk(s_clk), .rst_n(s_rst_n),
    .req_async(bus_req), .ack(bus_ack),
    .bus_addr(line_addr), .bus_write(line_write),
    .bus_wdata(line_wdata), .bus_rdata(line_rdata)
  );
endmodule

// File: rtl/hs_bus_checker.sv
module hs_bus_checker #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int DECODE_CYC = 3
) (
  input logic              m_clk,
  input logic              m_rst_n,
  input logic              s_clk,
  input logic              s_rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] line_addr,
  input logic              line_write,
  input logic [DATA_W-1:0] line_wdata
);
  localparam int CW = $clog2(DECODE_CYC + 2) + 2;
  logic [CW-1:0] since_accept;

  always_ff @(posedge m_clk or negedge m_rst_n) begin
    if (!m_rst_n)                    since_accept <= '0;
    else if (cmd_valid && cmd_ready) since_accept <= '0;
    else if (since_accept != '1)     since_accept <= since_accept + 1'b1;
  end

  // R2: no new command while a handshake is in flight
  a_r2_busy_blocks: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    bus_req |-> !cmd_ready);

  // R3: request waits out the decode interval (count of edges after acceptance)
  a_r3_decode_wait: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    $rose(bus_req) |-> since_accept >= CW'(DECODE_CYC));

  // R3: lines held while the handshake runs
  a_r3_lines_hold: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    bus_req |-> ($stable(line_addr) && $stable(line_write) && $stable(line_wdata)));

  // R4: acknowledge answers a live request
  a_r4_ack_needs_req: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    $rose(bus_ack) |-> bus_req);

  // R4: request drops only after acknowledge
  a_r4_drop_needs_ack: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    $fell(bus_req) |-> bus_ack);

  // R5: acknowledge returns only after request is gone
  a_r5_ack_release: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    $fell(bus_ack) |-> !bus_req);

  // R5: new request only after acknowledge is back low
  a_r5_req_after_release: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    $rose(bus_req) |-> !bus_ack);

  // R8: stalled response holds
  a_r8_rsp_hold: assert property (@(posedge m_clk) disable iff (!m_rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind hs_bus_top hs_bus_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DECODE_CYC(DECODE_CYC)
) u_hs_bus_checker (
  .m_clk(m_clk), .m_rst_n(m_rst_n), .s_clk(s_clk), .s_rst_n(s_rst_n),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .bus_req(bus_req), .bus_ack(bus_ack),
  .line_addr(line_addr), .line_write(line_write), .line_wdata(line_wdata)
);

// File: tb/tb_hs_bus_top.sv
module tb_hs_bus_top;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int DECODE_CYC = 3;
  localparam int DEPTH = 1 << ADDR_W;

  logic m_clk = 1'b0, s_clk = 1'b0;
  logic m_rst_n = 1'b0, s_rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, rsp_ready = 1'b1;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, bus_req, bus_ack;
  logic [DATA_W-1:0] rsp_rdata;

  always #4 m_clk = ~m_clk;       // 125 MHz
  always #6.7 s_clk = ~s_clk;     // unrelated slave clock

  hs_bus_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DECODE_CYC(DECODE_CYC)) dut (
    .m_clk(m_clk), .m_rst_n(m_rst_n), .s_clk(s_clk), .s_rst_n(s_rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .bus_req(bus_req), .bus_ack(bus_ack)
  );

  int n_cmp = 0, n_bad = 0, n_order_err = 0;
  bit done = 0;
  logic [DATA_W-1:0] shadow [DEPTH];

  task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] expect_read(input logic [ADDR_W-1:0] a);
    return shadow[a];
  endfunction

  // R4 R5: fine-grained sampler of the {req,ack} steps
  logic [1:0] prev_pair = 2'b00;
  always #1 begin
    if (m_rst_n && s_rst_n) begin
      logic [1:0] cur;
      cur = {bus_req, bus_ack};
      if (cur != prev_pair &&
          !((prev_pair == 2'b00 && cur == 2'b10) || (prev_pair == 2'b10 && cur == 2'b11) ||
            (prev_pair == 2'b11 && cur == 2'b01) || (prev_pair == 2'b01 && cur == 2'b00)))
        n_order_err++;
      prev_pair = cur;
    end
  end

  task automatic do_op(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                       input int stall, input bit meas, output logic [DATA_W-1:0] rd);
    int n;
    logic [DATA_W-1:0] held;
    @(negedge m_clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    rsp_ready = (stall == 0);
    while (!cmd_ready) @(negedge m_clk);
    @(posedge m_clk);
    @(negedge m_clk);
    cmd_valid = 1'b0;
    check(!cmd_ready, "R2 ready low after accept", 32'(cmd_ready), 0);
    if (meas) begin
      n = 0;
      while (!bus_req && n < 100) begin n++; @(negedge m_clk); end
      check(n == DECODE_CYC + 1, "R3 decode delay", 32'(n), 32'(DECODE_CYC + 1));
    end
    while (!rsp_valid) @(negedge m_clk);
    held = rsp_rdata;
    if (stall > 0) begin
      for (int k = 0; k < stall; k++) begin
        @(negedge m_clk);
        check(rsp_valid && rsp_rdata == held && !cmd_ready, "R8 stalled response held",
              rsp_rdata, held);
      end
      rsp_ready = 1'b1;
    end
    rd = rsp_rdata;
    @(posedge m_clk);
    @(negedge m_clk);
    check(!rsp_valid, "R8 single response", 32'(rsp_valid), 0);
    if (wr) begin
      check(rd == '0, "R8 write response zero", rd, '0);
      shadow[a] = d;
    end
  endtask

  task automatic finish_run();
    check(n_order_err == 0, "R5 four-phase ordering", 32'(n_order_err), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [DATA_W-1:0] rd;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    repeat (4) @(negedge m_clk);
    m_rst_n = 1'b1; s_rst_n = 1'b1;
    repeat (3) @(negedge m_clk);
    // R1 reset state
    check(cmd_ready, "R1 cmd_ready after reset", 32'(cmd_ready), 1);
    check(!rsp_valid && !bus_req && !bus_ack, "R1 idle lines after reset",
          {29'd0, rsp_valid, bus_req, bus_ack}, 0);

    // R7 unwritten location reads zero
    do_op(1'b0, 4'd9, '0, 0, 1'b1, rd);
    check(rd == '0, "R7 unwritten read zero", rd, '0);

    // R6 end addresses
    do_op(1'b1, 4'd0, 32'hA5A5_0001, 0, 1'b1, rd);
    do_op(1'b1, 4'd15, 32'h5A5A_FFFF, 0, 1'b0, rd);
    do_op(1'b0, 4'd0, '0, 0, 1'b0, rd);
    check(rd == expect_read(4'd0), "R6 readback addr 0", rd, expect_read(4'd0));
    do_op(1'b0, 4'd15, '0, 0, 1'b0, rd);
    check(rd == expect_read(4'd15), "R6 readback top addr", rd, expect_read(4'd15));

    // R6 last write wins
    do_op(1'b1, 4'd5, 32'h1111_1111, 0, 1'b0, rd);
    do_op(1'b1, 4'd5, 32'h2222_2222, 0, 1'b0, rd);
    do_op(1'b0, 4'd5, '0, 0, 1'b0, rd);
    check(rd == 32'h2222_2222, "R6 last write wins", rd, 32'h2222_2222);

    // R8 stalled read response
    do_op(1'b0, 4'd15, '0, 6, 1'b1, rd);
    check(rd == expect_read(4'd15), "R8 stalled read data", rd, expect_read(4'd15));

    // R6 random traffic against shadow model
    for (int i = 0; i < 300; i++) begin
      bit wr;
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      wr = $urandom_range(0, 1);
      a  = ADDR_W'($urandom_range(0, DEPTH - 1));
      d  = $urandom;
      do_op(wr, a, d, ($urandom_range(0, 7) == 0) ? 3 : 0, (i % 50) == 0, rd);
      if (!wr) check(rd == expect_read(a), "R6 random readback", rd, expect_read(a));
    end

    // R6 full sweep: every word reads back unchanged
    for (int i = 0; i < DEPTH; i++) begin
      do_op(1'b0, ADDR_W'(i), '0, 0, 1'b0, rd);
      check(rd == expect_read(ADDR_W'(i)), "R6 sweep readback", rd, expect_read(ADDR_W'(i)));
    end

    done = 1;
    finish_run();
  end
endmodule